// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the front end of a single transmit DMA channel. Software builds a ring of four-word descriptors in memory. Each descriptor holds a status word, a control word, a buffer address and a next-descriptor word, at byte offsets 0, 4, 8 and 12. Software then pulses a poll strobe. The engine reads the status word at the current ring position. If hardware owns that descriptor, the engine reads the control word and the buffer address. It then streams the buffer's bytes onto a valid/ready byte output, writes the status word back with ownership returned to software, and moves on to the next descriptor. It keeps walking until it meets a descriptor that software owns, and then it waits for another strobe.

The current ring position is kept as an offset from the `base_addr` input. Without an end-of-ring mark each descriptor sits 16 bytes after the previous one. An end-of-ring mark returns the walk to the base address. A frame may span several descriptors, which are marked with first-segment and last-segment bits. The stream's last marker follows the last-segment bit. An abort reported by the stream consumer is folded into the written-back status as an error flag.

Memory words are little-endian. The byte at address A is bits `8*(A mod 4)+7 : 8*(A mod 4)` of the word at `A & ~3`. A buffer may begin at any byte address.

Top module: `txdesc_walker`

## Requirements
- R1: After reset the engine is idle, with `mem_req`, `out_valid` and `out_last` all low.
- R2: A `poll` pulse while idle makes the engine read the status word at `base_addr + offset`. If bit 31 of that word is 0 (software-owned), the engine returns to idle. It reads that descriptor exactly once and makes no further memory access.
- R3: If status bit 31 is 1, the engine reads the control word at +4 and the buffer address at +8. It then emits exactly `control[10:0]` bytes, taken in address order from the buffer address, which may be unaligned.
- R4: `out_last` is high only on the final byte of a descriptor whose control bit 30 (last segment) is set. It is never high on other bytes, or for descriptors with bit 30 clear.
- R5: On completion the engine writes the status word at +0 with bit 31 = 0, bit 15 = error and all other bits 0. The error flag is cleared when a control word with bit 29 (first segment) set is read. It is set when `out_abort` is high while bytes are being fetched or emitted. `out_abort` has no effect in any other phase.
- R6: After the write-back the engine reads the next status word at once. If control bit 25 (end of ring) was clear, that word is at the current address + 16. If it was set, the word is at `base_addr`.
- R7: A descriptor with control bit 27 (setup frame) set, or with a byte count of 0, emits no bytes and is still written back.
- R8: A `poll` pulse that arrives while the engine is busy is remembered. When the walk next finds a software-owned descriptor, that descriptor is read once more instead of the engine going idle.
- R9: `out_data` and `out_last` hold steady while `out_valid` is high and `out_ready` is low. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Byte address of the first ring descriptor |
| poll | input | 1 | One-cycle poll-demand strobe |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (status write-back) |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream consumer ready |
| out_last | output | 1 | Final byte of a frame |
| out_abort | input | 1 | Consumer reports the current frame aborted |

## Verification
Two functions can fall in the same cycle: the ownership read that ends a walk on a software-owned descriptor, and a poll demand that would otherwise be lost because the engine is not idle. The bench pulses `poll` while the engine is busy fetching and streaming under random back-pressure. It then counts how many times the memory model serves a read of the terminating descriptor's status address, and expects exactly two such reads where a plain walk gives one. The abort-versus-first-segment interplay is judged from the written-back status words of a setup descriptor, an aborted frame and a later clean frame.

// File: rtl/txdesc_walker.sv
module txdesc_walker #(
  parameter int CNT_W  = 11,
  parameter int STRIDE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] base_addr,
  input  logic        poll,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_last,
  input  logic        out_abort
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [31:0] STEP = 32'(STRIDE);

  typedef enum logic [2:0] {IDLE, STS, CTL, BUF, WORD, EMIT, WB} st_t;
  st_t state;

  logic [31:0]      off, bp, word;
  logic [CNT_W-1:0] rem;
  logic             f_last, f_eor, f_setup, err, pend;

  wire [31:0] cur = base_addr + off;

  assign mem_req   = (state == STS) || (state == CTL) || (state == BUF) ||
                     (state == WORD) || (state == WB);
  assign mem_we    = (state == WB);
  assign mem_wdata = {16'h0, err, 15'h0};
  assign out_valid = (state == EMIT);
  assign out_data  = word[{bp[1:0], 3'b000} +: 8];
  assign out_last  = out_valid && f_last && (rem == ONE);

  always_comb begin
    case (state)
      CTL:     mem_addr = cur + 32'd4;
      BUF:     mem_addr = cur + 32'd8;
      WORD:    mem_addr = {bp[31:2], 2'b00};
      default: mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; off <= '0; bp <= '0; word <= '0; rem <= '0;
      f_last <= 1'b0; f_eor <= 1'b0; f_setup <= 1'b0; err <= 1'b0; pend <= 1'b0;
    end else begin
      if (poll && state != IDLE) pend <= 1'b1;
      if (out_abort && (state == WORD || state == EMIT)) err <= 1'b1;
      case (state)
        IDLE: if (poll) state <= STS;
        STS: if (mem_ack) begin
          if (mem_rdata[31]) state <= CTL;
          else begin
            pend  <= 1'b0;
            state <= (pend || poll) ? STS : IDLE;
          end
        end
        CTL: if (mem_ack) begin
          rem     <= mem_rdata[CNT_W-1:0];
          f_last  <= mem_rdata[30];
          f_setup <= mem_rdata[27];
          f_eor   <= mem_rdata[25];
          if (mem_rdata[29]) err <= 1'b0;
          state <= BUF;
        end
        BUF: if (mem_ack) begin
          bp    <= mem_rdata;
          state <= (f_setup || rem == '0) ? WB : WORD;
        end
        WORD: if (mem_ack) begin
          word  <= mem_rdata;
          state <= EMIT;
        end
        EMIT: if (out_ready) begin
          rem <= rem - ONE;
          bp  <= bp + 32'd1;
          if (rem == ONE) state <= WB;
          else if (bp[1:0] == 2'b11) state <= WORD;
        end
        WB: if (mem_ack) begin
          off   <= f_eor ? 32'd0 : off + STEP;
          state <= STS;
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R6
  ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we &&
      (mem_addr == $past(mem_addr) + STEP || mem_addr == base_addr));

  // R2
  poll_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && !out_valid && poll |=> mem_req && !mem_we && mem_addr == base_addr + off);

  // R4
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);
endmodule

// File: tb/sim_txdesc_walker.sv
module sim_txdesc_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] OWN = 32'h8000_0000, LAST = 32'h4000_0000,
                          FIRST = 32'h2000_0000, SETUP = 32'h0800_0000,
                          EOR = 32'h0200_0000;

  logic clk = 0, rst_n = 0, poll = 0, out_ready = 1, out_abort = 0, stall = 0;
  logic mem_req, mem_we, mem_ack = 0, out_valid, out_last;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [7:0] out_data;

  logic [31:0] mem [0:255];
  int rd_cnt = 0, watch_cnt = 0, ngot = 0, checks = 0, failures = 0;
  logic [31:0] last_rd = 0, watch = 0;
  logic [7:0] got [0:63];
  logic glast [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_walker u0 (.clk(clk), .rst_n(rst_n), .base_addr(BASE), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last), .out_abort(out_abort));

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1;
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else begin
        rd_cnt <= rd_cnt + 1;
        last_rd <= mem_addr;
        if (mem_addr == watch) watch_cnt <= watch_cnt + 1;
      end
    end else mem_ack <= 0;
  end

  always @(negedge clk)
    if (out_valid && out_ready && ngot < 64) begin
      got[ngot] = out_data; glast[ngot] = out_last; ngot = ngot + 1;
    end

  initial forever begin
    @(posedge clk); #1;
    out_ready = stall ? 1'($urandom % 2) : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bytes(input logic [31:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [31:0] x = a + 32'(i);
      mem[x[9:2]][{x[1:0], 3'b000} +: 8] = seed + 8'(i);
    end
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] c,
                          input logic [31:0] b);
    mem[a[9:2]] = s; mem[a[9:2] + 1] = c; mem[a[9:2] + 2] = b; mem[a[9:2] + 3] = 0;
  endtask

  task automatic pulse_poll;
    @(posedge clk); #1 poll = 1;
    @(posedge clk); #1 poll = 0;
  endtask

  task automatic start(input logic [31:0] w);
    ngot = 0; rd_cnt = 0; watch_cnt = 0; watch = w;
  endtask

  task automatic settle;
    repeat (150) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_stream(input string req, input int n, input logic [7:0] seed, input bit lastflag);
    chk({req, " byte count"}, 32'(ngot), 32'(n));
    for (int i = 0; i < n && i < ngot; i++) begin
      chk({req, " byte"}, 32'(got[i]), 32'(seed + 8'(i)));
      chk("R4 last marker", 32'(glast[i]), 32'(lastflag && i == n - 1));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 out_last", 32'(out_last), 0);
  endtask

  task automatic t_sw_owned;
    set_desc(BASE, 0, FIRST | LAST | 4, 32'h200);
    start(BASE);
    pulse_poll; settle;
    chk("R2 single read", 32'(watch_cnt), 1);
    chk("R2 total reads", 32'(rd_cnt), 1);
    chk("R2 no bytes", 32'(ngot), 0);
    chk("R2 idle", 32'(mem_req), 0);
  endtask

  task automatic t_single;
    set_desc(BASE, OWN, FIRST | LAST | 5, 32'h201);
    set_desc(BASE + 16, 0, 0, 0);
    put_bytes(32'h201, 5, 8'h10);
    start(BASE + 16);
    pulse_poll; settle;
    chk_stream("R3 unaligned", 5, 8'h10, 1);
    chk("R5 status cleared", mem[BASE[9:2]], 0);
    chk("R6 next at +16", last_rd, BASE + 16);
  endtask

  task automatic t_multi_wrap;
    set_desc(BASE + 16, OWN, FIRST | 3, 32'h240);
    set_desc(BASE + 32, OWN, LAST | EOR | 4, 32'h252);
    put_bytes(32'h240, 3, 8'h40);
    put_bytes(32'h252, 4, 8'h43);
    start(BASE);
    stall = 1;
    pulse_poll; settle;
    stall = 0;
    chk_stream("R3 two segments stalled R9", 7, 8'h40, 1);
    chk("R5 seg1 status", mem[BASE[9:2] + 4], 0);
    chk("R5 seg2 status", mem[BASE[9:2] + 8], 0);
    chk("R6 wrap to base", last_rd, BASE);
  endtask

  task automatic t_setup_abort;
    set_desc(BASE, OWN, SETUP | 8, 32'h280);
    set_desc(BASE + 16, OWN, FIRST | LAST | 2, 32'h260);
    set_desc(BASE + 32, 0, 0, 0);
    put_bytes(32'h260, 2, 8'h60);
    put_bytes(32'h280, 8, 8'hA0);
    start(BASE + 32);
    out_abort = 1;
    pulse_poll; settle;
    out_abort = 0;
    chk_stream("R7 setup skipped", 2, 8'h60, 1);
    chk("R7 R5 setup status no error", mem[BASE[9:2]], 0);
    chk("R5 abort error bit", mem[BASE[9:2] + 4], 32'h0000_8000);
    chk("R6 stop at +32", last_rd, BASE + 32);
  endtask

  task automatic t_busy_poll;
    set_desc(BASE + 32, OWN, FIRST | LAST | 4, 32'h270);
    set_desc(BASE + 48, 0, 0, 0);
    put_bytes(32'h270, 4, 8'h70);
    start(BASE + 48);
    stall = 1;
    pulse_poll;
    repeat (4) @(posedge clk);
    pulse_poll; settle;
    stall = 0;
    chk_stream("R8 stream", 4, 8'h70, 1);
    chk("R8 refetch count", 32'(watch_cnt), 2);
    chk("R5 first segment clears error", mem[BASE[9:2] + 8], 0);
    chk("R8 idle after", 32'(mem_req), 0);
  endtask

  task automatic t_zero_len;
    set_desc(BASE + 48, OWN, FIRST | LAST | EOR, 32'h2C0);
    start(BASE);
    pulse_poll; settle;
    chk("R7 zero count no bytes", 32'(ngot), 0);
    chk("R7 zero count written back", mem[BASE[9:2] + 12], 0);
    chk("R6 end of ring to base", last_rd, BASE);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(posedge clk);
    t_reset;
    @(posedge clk); #1 rst_n = 1;
    t_sw_owned;
    t_single;
    t_multi_wrap;
    t_setup_abort;
    t_busy_poll;
    t_zero_len;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule